// File: doc/BRIEF.md
# Chainable Preset Up-Counter

This block is a synchronous binary up-counter, sixteen states wide by default, that can be preset from a parallel data word and cleared by an active-low reset. It has two count enables. A count step happens only when both are high. A combinational terminal-count flag rises at the all-ones state, gated only by the second enable.

Several copies chain into a wider synchronous counter. One common count enable drives the first enable of every stage. Each stage's terminal count drives the second enable of the next stage up. Every stage then advances on the same clock edge.

A build-time parameter selects how the clear acts. In the asynchronous form the counter clears at once, with no clock edge. In the synchronous form it clears on the next rising edge. Both forms share one RTL body.

Top module: `preset_counter`

## Requirements
- R1: With rst_n, load_n, cnt_en_p and cnt_en_t all high, count rises by one on each rising edge and wraps from all ones (15) to 0.
- R2: Modes have fixed precedence on a rising edge: clear first, then preset load, then count step, then hold. A clear in the same cycle as a load leaves count at 0. A load in the same cycle as enabled counting takes the preset value.
- R3: With ASYNC_CLR=1, a low rst_n drives count to 0 at once, before any clock edge, and keeps it there while low.
- R4: With ASYNC_CLR=0, a low rst_n leaves count unchanged until the next rising edge, which then sets count to 0.
- R5: With rst_n high and load_n low, the next rising edge copies preset into count, whatever cnt_en_p and cnt_en_t are.
- R6: With rst_n and load_n high, count keeps its value across an edge when either cnt_en_p or cnt_en_t is low.
- R7: term_cnt is high exactly when count is all ones (15) and cnt_en_t is high. It follows cnt_en_t without a clock and ignores cnt_en_p.
- R8: Two stages wired low-to-high form an 8-bit counter that steps from 255 to 0. In this wiring, the lower term_cnt drives the upper cnt_en_t, and both cnt_en_p inputs and the lower cnt_en_t share one enable.
- R9: With a load pending at count 15, term_cnt stays high until the edge and then reflects the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low preset load |
| preset | input | WIDTH | Value copied into the counter on load |
| cnt_en_p | input | 1 | Count enable shared across a chain |
| cnt_en_t | input | 1 | Count enable that also gates term_cnt |
| count | output | WIDTH | Current counter state |
| term_cnt | output | 1 | High at all ones while cnt_en_t is high |

## Verification
Several control inputs can be active in one cycle, and precedence decides the result. The bench sets the counter to all ones and then asserts load together with both enables, and separately asserts clear together with load. The expected result is that the load wins over the step and the clear wins over the load. Terminal count can also change in the same cycle as a load. The flag is sampled half a period before and after that edge and compared with the reference model's state. The synchronous and asynchronous builds run side by side, so one stimulus shows the clear acting at once in one build and waiting for the edge in the other.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_STEP  = 2'd1,
    M_LOAD  = 2'd2,
    M_CLEAR = 2'd3
  } pcnt_mode_e;

  // Precedence: clear, load, step, hold.
  function automatic pcnt_mode_e pick_mode(input logic clr_req,
                                           input logic load_n,
                                           input logic en_p,
                                           input logic en_t);
    if (clr_req)         return M_CLEAR;
    if (!load_n)         return M_LOAD;
    if (en_p && en_t)    return M_STEP;
    return M_HOLD;
  endfunction

endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
  import pcnt_pkg::*;
(
  input  logic clr_req,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  output logic clear_ev,
  output logic load_ev,
  output logic step_ev
);

  pcnt_mode_e mode;

  always_comb begin
    mode     = pick_mode(clr_req, load_n, en_p, en_t);
    clear_ev = (mode == M_CLEAR);
    load_ev  = (mode == M_LOAD);
    step_ev  = (mode == M_STEP);
  end

endmodule

// File: rtl/pcnt_state_reg.sv
module pcnt_state_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_ev,
  input  logic             load_ev,
  input  logic             step_ev,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  function automatic logic [WIDTH-1:0] bump(input logic [WIDTH-1:0] v);
    return v + WIDTH'(1);
  endfunction

  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = q;
    if (clear_ev)     q_next = ZERO;
    else if (load_ev) q_next = preset;
    else if (step_ev) q_next = bump(q);
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ZERO;
        else        q <= q_next;
      end
    end else begin : g_sync
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
        q <= q_next;
      end
    end
  endgenerate

endmodule

// File: rtl/pcnt_term_det.sv
module pcnt_term_det #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             at_max,
  output logic             term
);

  always_comb begin
    at_max = &q;
    term   = at_max & en_t;
  end

endmodule

// File: rtl/preset_counter.sv
module preset_counter #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_en_p,
  input  logic             cnt_en_t,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);

  logic clr_req;
  logic clear_ev;
  logic load_ev;
  logic step_ev;
  logic at_max;

  assign clr_req = ~rst_n;

  pcnt_mode_dec u_dec (
    .clr_req (clr_req),
    .load_n  (load_n),
    .en_p    (cnt_en_p),
    .en_t    (cnt_en_t),
    .clear_ev(clear_ev),
    .load_ev (load_ev),
    .step_ev (step_ev)
  );

  pcnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_ev(clear_ev),
    .load_ev (load_ev),
    .step_ev (step_ev),
    .preset  (preset),
    .q       (count)
  );

  pcnt_term_det #(.WIDTH(WIDTH)) u_term (
    .q     (count),
    .en_t  (cnt_en_t),
    .at_max(at_max),
    .term  (term_cnt)
  );

endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic             cnt_en_p,
  input logic             cnt_en_t,
  input logic [WIDTH-1:0] count,
  input logic             term_cnt,
  input logic             step_ev,
  input logic             at_max
);

  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> count == WIDTH'($past(count) + WIDTH'(1)));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && at_max) |=> count == '0);

  p_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && cnt_en_p && cnt_en_t) |-> !step_ev);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

  p_tc_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (cnt_en_t && (&count)));

  p_tc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_t && (&count)) |-> term_cnt);

  generate
    if (ASYNC_CLR) begin : g_ac
      p_aclr_r3: assert property (@(posedge clk)
        (started && !rst_n) |-> count == '0);
    end else begin : g_sc
      p_sclr_r4: assert property (@(posedge clk)
        !rst_n |=> count == '0);
    end
  endgenerate

endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_n  (load_n),
  .preset  (preset),
  .cnt_en_p(cnt_en_p),
  .cnt_en_t(cnt_en_t),
  .count   (count),
  .term_cnt(term_cnt),
  .step_ev (step_ev),
  .at_max  (at_max)
);

// File: tb/tb_preset_counter.sv
`timescale 1ns/1ps
module tb_preset_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;
  logic       c_en = 1'b0;

  logic [3:0] cnt_a, cnt_s, cnt_lo, cnt_hi;
  logic       tc_a, tc_s, tc_lo, tc_hi;

  int errors = 0;
  int checks = 0;
  bit live = 1'b0;
  string phase = "R2 reset";

  int m_a = 0;
  int m_s = 0;
  int m_8 = 0;

  always #5 clk = ~clk;

  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(preset),
    .cnt_en_p(en_p), .cnt_en_t(en_t), .count(cnt_a), .term_cnt(tc_a));

  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(preset),
    .cnt_en_p(en_p), .cnt_en_t(en_t), .count(cnt_s), .term_cnt(tc_s));

  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_lo (
    .clk(clk), .rst_n(rst_n), .load_n(1'b1), .preset(4'd0),
    .cnt_en_p(c_en), .cnt_en_t(c_en), .count(cnt_lo), .term_cnt(tc_lo));

  preset_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .load_n(1'b1), .preset(4'd0),
    .cnt_en_p(c_en), .cnt_en_t(tc_lo), .count(cnt_hi), .term_cnt(tc_hi));

  // Reference models: plain integer arithmetic per the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)            m_a <= 0;
    else if (!load_n)      m_a <= int'(preset);
    else if (en_p && en_t) m_a <= (m_a + 1) % 16;
  end

  always @(posedge clk) begin
    if (!rst_n)            m_s <= 0;
    else if (!load_n)      m_s <= int'(preset);
    else if (en_p && en_t) m_s <= (m_s + 1) % 16;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)    m_8 <= 0;
    else if (c_en) m_8 <= (m_8 + 1) % 256;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({phase, " async count"}, int'(cnt_a), m_a);
    chk({phase, " async tc R7"}, int'(tc_a), int'(m_a == 15 && en_t));
    chk({phase, " sync count"},  int'(cnt_s), m_s);
    chk({phase, " sync tc R7"},  int'(tc_s), int'(m_s == 15 && en_t));
    chk({phase, " R8 chain"},    int'({cnt_hi, cnt_lo}), m_8);
    chk({phase, " R8 chain tc"}, int'(tc_hi), int'(m_8 == 255 && c_en));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (live) compare_all();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    live = 1'b1;
    tick();                          // reset state, R2
    rst_n = 1'b1;
    tick();

    phase = "R1 count";
    en_p = 1'b1; en_t = 1'b1;
    repeat (20) tick();

    phase = "R6 hold";
    en_p = 1'b0;
    repeat (3) tick();
    en_p = 1'b1; en_t = 1'b0;
    repeat (3) tick();

    phase = "R5 load";
    load_n = 1'b0; preset = 4'd10; en_p = 1'b0; en_t = 1'b0;
    tick();
    preset = 4'd6; en_p = 1'b1; en_t = 1'b1;   // load beats step, R2
    tick();

    phase = "R7 tc";
    preset = 4'd15; en_p = 1'b0; en_t = 1'b1;
    tick();
    load_n = 1'b1;
    tick();
    en_t = 1'b0;
    #1 chk("R7 tc drops with cnt_en_t", int'(tc_a), 0);
    en_t = 1'b1;
    #1 chk("R7 tc follows cnt_en_t", int'(tc_a), 1);
    tick();

    phase = "R9 load at 15";
    load_n = 1'b0; preset = 4'd3; en_p = 1'b1;
    #1 chk("R9 tc before edge", int'(tc_a), 1);
    tick();
    chk("R9 tc after edge", int'(tc_a), 0);
    chk("R9 loaded count", int'(cnt_a), 3);

    phase = "R2 clear over load";
    rst_n = 1'b0; load_n = 1'b0; preset = 4'd9;
    #1 chk("R3 async clear at once", int'(cnt_a), 0);
    chk("R4 sync holds before edge", int'(cnt_s), 3);
    tick();
    chk("R4 sync cleared at edge", int'(cnt_s), 0);
    chk("R2 clear beats load", int'(cnt_a), 0);
    rst_n = 1'b1; load_n = 1'b1;
    tick();
    tick();

    phase = "R3 R4 mid-count clear";
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1 chk("R3 async clear between edges", int'(cnt_a), 0);
    chk("R4 sync unchanged between edges", int'(cnt_s), m_s);
    @(negedge clk);
    compare_all();
    tick();
    rst_n = 1'b1;
    tick();

    phase = "R8 cascade";
    en_p = 1'b0; en_t = 1'b0;
    c_en = 1'b1;
    repeat (300) tick();
    c_en = 1'b0;
    repeat (2) tick();

    summary();
    $finish;
  end

endmodule